// File: doc/BRIEF.md
# Display Condition Register with Interrupt Channel Decode

This block holds the fourteen condition flags of a point-plotting display interface that sits on a 36-bit I/O bus. The host configures it with a condition-out pair of pulses: a clear pulse that zeroes the register, then a set pulse that ORs bus bits into the twelve writable flags. The host reads it with a condition-in status strobe, which places all fourteen flags on the bus for as long as the strobe is high. Two flags are owned by the display side and cannot be written by the host. The busy flag follows the load-display and display-done pulses. The light-pen flag is set by the pen and cleared when a status read ends.

The register also decodes two 3-bit interrupt channel fields, one for the light-pen source and one for the ready source. Each field drives a one-hot request on seven channel lines, and the two results are ORed onto one shared request bus. The intensity code and the two axis-select flags are exported for the data path that sits next to this block.

All pulses are one-clock strobes in the block's clock domain. Address decoding and transfer sequencing are handled outside the block.

Top module: `disp_cond_reg`

## Requirements
- R1: After reset, or after a cycle with `cond_clr` or `bus_reset` high and `cond_set` low, all fourteen flags are zero. A clear also overrides any load, done, pen or data-clear event in the same cycle.
- R2: `cond_set` ORs `wr_word[11:0]` (bus bits 24..35) into the writable flags. In the same cycle it is applied after any clear. `wr_word[35:12]` is ignored, so the host can never set busy or light-pen.
- R3: `load_pulse` sets busy and `done_pulse` clears it. When both arrive in the same cycle, load wins.
- R4: `pen_hit` sets the light-pen flag, which then holds until a status-read end or a clear. A `pen_hit` in the same cycle as a read end leaves the flag set.
- R5: `load_pulse` sets ready and `data_clr` clears it. When both arrive in the same cycle, load wins.
- R6: While `stat_rd` is high, `rd_word[13:0]` carries the flags and every other bit is zero. From bit 13 down, the layout is: busy, pen, ready, y_only, x_only, intensity[2:0], pen channel[2:0] (bits 5:3), ready channel[2:0] (bits 2:0). While `stat_rd` is low, `rd_word` is zero.
- R7: At the first clock edge where `stat_rd` is sampled low after being high, the light-pen flag clears. The flag stays set while the strobe is high.
- R8: For each source, `irq_req[k-1]` is high when that source's channel field equals k (1..7) and its flag (pen or ready) is 1. A channel value of 0 drives no line. The two sources are ORed together.
- R9: `inten`, `y_only` and `x_only` follow their flags. `inten` is two's complement: 3'b100 is the dimmest level and 3'b011 is the brightest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse, clears all flags |
| cond_clr | input | 1 | Condition-out clear pulse |
| cond_set | input | 1 | Condition-out set pulse |
| wr_word | input | 36 | Bus data for condition-out set |
| stat_rd | input | 1 | Status read strobe (level) |
| rd_word | output | 36 | Status readback word |
| load_pulse | input | 1 | Load-display pulse |
| done_pulse | input | 1 | Display-done pulse |
| pen_hit | input | 1 | Light pen saw the spot |
| data_clr | input | 1 | Data-out clear pulse |
| irq_req | output | 7 | Interrupt request per channel 1..7 |
| disp_busy | output | 1 | Busy flag |
| if_ready | output | 1 | Ready flag |
| inten | output | 3 | Intensity code |
| y_only | output | 1 | Y-only axis select flag |
| x_only | output | 1 | X-only axis select flag |

## Verification
The bench first writes an all-ones word with a set pulse. Only the twelve writable flags should respond, which shows both the write mask and that the bus bits above the flag field are ignored. Configurations with distinct, equal and zero channel fields separate three cases: correct one-hot decoding, the OR of the two sources, and the disabled code. Each flag pair is driven with its set and clear events both one at a time and together, which reveals the priority chosen for simultaneous events. A read strobe is timed against `pen_hit` to locate the cycle in which the read clears the light-pen flag, and to confirm that a coincident hit wins.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int CHAN_W   = 3;
  localparam int NUM_CHAN = (1 << CHAN_W) - 1;
  localparam int INT_W    = 3;
  localparam int FLAG_W   = 5 + INT_W + 2 * CHAN_W;
  localparam int WR_W     = FLAG_W - 2;

  typedef struct packed {
    logic              busy;
    logic              pen;
    logic              ready;
    logic              y_only;
    logic              x_only;
    logic [INT_W-1:0]  inten;
    logic [CHAN_W-1:0] pen_chan;
    logic [CHAN_W-1:0] rdy_chan;
  } dcr_flags_t;

  function automatic dcr_flags_t or_writable(dcr_flags_t f, logic [WR_W-1:0] bits);
    logic [FLAG_W-1:0] v;
    v = f;
    v[WR_W-1:0] = v[WR_W-1:0] | bits;
    return dcr_flags_t'(v);
  endfunction

  function automatic logic [NUM_CHAN-1:0] chan_onehot(logic [CHAN_W-1:0] ch, logic en);
    logic [NUM_CHAN-1:0] r;
    r = '0;
    for (int k = 1; k <= NUM_CHAN; k++)
      if (en && ch == CHAN_W'(k)) r[k-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/dcr_edge_det.sv
module dcr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;

  assign fall = prev_q & ~lvl;

  // R7: a detected end of strobe only ever follows a sampled high level
  a_r7_fall_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(lvl));
endmodule

// File: rtl/dcr_chan_dec.sv
module dcr_chan_dec import dcr_pkg::*; (
  input  logic [CHAN_W-1:0]   ch,
  input  logic                en,
  output logic [NUM_CHAN-1:0] req
);
  assign req = chan_onehot(ch, en);

  always_comb begin
    // R8: at most one line per source, none for channel 0 or an idle flag
    a_r8_onehot: assert ($onehot0(req));
    a_r8_zero_off: assert (!((ch == '0 || !en) && req != '0));
  end
endmodule

// File: rtl/dcr_flag_reg.sv
module dcr_flag_reg import dcr_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            set,
  input  logic [WR_W-1:0] set_bits,
  input  logic            load,
  input  logic            done,
  input  logic            data_clr,
  input  logic            pen_hit,
  input  logic            rd_end,
  output dcr_flags_t      flags
);
  dcr_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (clr) begin
      nxt = '0;
    end else begin
      if (load)         nxt.busy = 1'b1;
      else if (done)    nxt.busy = 1'b0;
      if (pen_hit)      nxt.pen = 1'b1;
      else if (rd_end)  nxt.pen = 1'b0;
      if (load)         nxt.ready = 1'b1;
      else if (data_clr) nxt.ready = 1'b0;
    end
    if (set) nxt = or_writable(nxt, set_bits);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= nxt;

  // R1: a clear without a set leaves every flag at zero
  a_r1_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> flags == '0);
  // R2: the host set cannot raise busy or pen
  a_r2_no_host_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.busy && !load |=> !flags.busy);
  a_r2_no_host_pen: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.pen && !pen_hit |=> !flags.pen);
  // R3: load sets busy unless cleared in the same cycle
  a_r3_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> flags.busy);
  // R4: pen flag holds without a read end or clear
  a_r4_pen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flags.pen && !rd_end && !clr |=> flags.pen);
  // R5: data clear drops ready unless load or a set of that bit intervene
  a_r5_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    data_clr && !load && !set |=> !flags.ready);
  // R7: the end of a read clears the pen flag unless a hit arrives with it
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end && !pen_hit |=> !flags.pen);
endmodule

// File: rtl/disp_cond_reg.sv
module disp_cond_reg import dcr_pkg::*; #(
  parameter int BUS_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_reset,
  input  logic                cond_clr,
  input  logic                cond_set,
  input  logic [BUS_W-1:0]    wr_word,
  input  logic                stat_rd,
  output logic [BUS_W-1:0]    rd_word,
  input  logic                load_pulse,
  input  logic                done_pulse,
  input  logic                pen_hit,
  input  logic                data_clr,
  output logic [NUM_CHAN-1:0] irq_req,
  output logic                disp_busy,
  output logic                if_ready,
  output logic [INT_W-1:0]    inten,
  output logic                y_only,
  output logic                x_only
);
  localparam int PAD_W = BUS_W - FLAG_W;

  dcr_flags_t          flags;
  logic                any_clr;
  logic                rd_end;
  logic [NUM_CHAN-1:0] pen_req;
  logic [NUM_CHAN-1:0] rdy_req;

  assign any_clr = cond_clr | bus_reset;

  dcr_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stat_rd), .fall(rd_end)
  );

  dcr_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .clr(any_clr), .set(cond_set),
    .set_bits(wr_word[WR_W-1:0]), .load(load_pulse), .done(done_pulse),
    .data_clr(data_clr), .pen_hit(pen_hit), .rd_end(rd_end), .flags(flags)
  );

  dcr_chan_dec u_pen_dec (.ch(flags.pen_chan), .en(flags.pen),   .req(pen_req));
  dcr_chan_dec u_rdy_dec (.ch(flags.rdy_chan), .en(flags.ready), .req(rdy_req));

  assign irq_req   = pen_req | rdy_req;
  assign rd_word   = stat_rd ? {{PAD_W{1'b0}}, flags} : '0;
  assign disp_busy = flags.busy;
  assign if_ready  = flags.ready;
  assign inten     = flags.inten;
  assign y_only    = flags.y_only;
  assign x_only    = flags.x_only;

  // R6: nothing outside the flag field ever reaches the bus
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[BUS_W-1:FLAG_W] == '0);
  // R8: with both sources idle, no request line is high
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.pen && !flags.ready |-> irq_req == '0);
endmodule

// File: tb/tb_disp_cond_reg.sv
module tb_disp_cond_reg;
  logic clk = 0, rst_n = 0;
  logic bus_reset = 0, cond_clr = 0, cond_set = 0, stat_rd = 0;
  logic load_pulse = 0, done_pulse = 0, pen_hit = 0, data_clr = 0;
  logic [35:0] wr_word = '0;
  logic [35:0] rd_word;
  logic [6:0]  irq_req;
  logic disp_busy, if_ready, y_only, x_only;
  logic [2:0] inten;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  disp_cond_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cond_clr(cond_clr),
    .cond_set(cond_set), .wr_word(wr_word), .stat_rd(stat_rd), .rd_word(rd_word),
    .load_pulse(load_pulse), .done_pulse(done_pulse), .pen_hit(pen_hit),
    .data_clr(data_clr), .irq_req(irq_req), .disp_busy(disp_busy),
    .if_ready(if_ready), .inten(inten), .y_only(y_only), .x_only(x_only)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: flags kept as plain bits, updated on each rising edge
  bit m_busy, m_pen, m_rdy, m_prev;
  bit [11:0] m_wr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pen = 0; m_rdy = 0; m_prev = 0; m_wr = 0;
    end else begin
      if (cond_clr || bus_reset) begin
        m_busy = 0; m_pen = 0; m_rdy = 0; m_wr = 0;
      end else begin
        if (load_pulse) m_busy = 1; else if (done_pulse) m_busy = 0;
        if (pen_hit) m_pen = 1; else if (m_prev && !stat_rd) m_pen = 0;
        if (load_pulse) m_rdy = 1; else if (data_clr) m_rdy = 0;
      end
      if (cond_set) begin
        m_wr = m_wr | wr_word[11:0];
        if (wr_word[11]) m_rdy = 1;
      end
      m_prev = stat_rd;
    end
  end

  function automatic logic [6:0] exp_irq();
    logic [6:0] r = '0;
    int pc = int'(m_wr[5:3]);
    int rc = int'(m_wr[2:0]);
    if (m_pen && pc != 0) r[pc-1] = 1'b1;
    if (m_rdy && rc != 0) r[rc-1] = 1'b1;
    return r;
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [35:0] e;
      e = stat_rd ? {22'b0, m_busy, m_pen, m_rdy, m_wr[10:0]} : 36'b0;
      chk(rd_word == e, "R6 model readback", rd_word, e);
      chk(irq_req == exp_irq(), "R8 model irq", 36'(irq_req), 36'(exp_irq()));
      chk(disp_busy == m_busy, "R3 model busy", 36'(disp_busy), 36'(m_busy));
      chk(if_ready == m_rdy, "R5 model ready", 36'(if_ready), 36'(m_rdy));
      chk({inten, y_only, x_only} == {m_wr[8:6], m_wr[10], m_wr[9]}, "R9 model fields",
          36'({inten, y_only, x_only}), 36'({m_wr[8:6], m_wr[10], m_wr[9]}));
    end
  end

  // ev bits: 6 bus_reset, 5 cond_clr, 4 cond_set, 3 load, 2 done, 1 pen, 0 data_clr
  task automatic cyc(input logic [6:0] ev);
    @(negedge clk);
    {bus_reset, cond_clr, cond_set, load_pulse, done_pulse, pen_hit, data_clr} = ev;
    @(negedge clk);
    {bus_reset, cond_clr, cond_set, load_pulse, done_pulse, pen_hit, data_clr} = '0;
    #2;
  endtask

  localparam logic [6:0] E_RST = 7'h40, E_CLR = 7'h20, E_SET = 7'h10, E_LD = 7'h08,
                         E_DN = 7'h04, E_PEN = 7'h02, E_DCL = 7'h01;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); stat_rd = 1; #2;
    chk(rd_word == 0, "R1 reset flags", rd_word, 0);
    @(negedge clk); stat_rd = 0;

    wr_word = 36'hFFF; cyc(E_SET);
    chk(if_ready && inten == 3'b111 && y_only && x_only, "R2 set writable", 36'({if_ready, inten, y_only, x_only}), 36'h3F);
    chk(!disp_busy, "R2 busy not host settable", 36'(disp_busy), 0);
    chk(irq_req == 7'h40, "R8 ready on channel 7", 36'(irq_req), 36'h40);
    @(negedge clk); stat_rd = 1; #2;
    chk(rd_word == 36'hFFF, "R6 readback all writable", rd_word, 36'hFFF);
    @(negedge clk); stat_rd = 0;

    cyc(E_CLR);
    chk(!if_ready && inten == 0 && irq_req == 0, "R1 cond clear", 36'({if_ready, inten, irq_req}), 0);
    cyc(E_SET); cyc(E_RST);
    chk(!if_ready && !y_only, "R1 bus reset", 36'({if_ready, y_only}), 0);

    wr_word = 36'h32B; cyc(E_CLR | E_SET);
    chk(inten == 3'b100 && x_only && !y_only, "R9 dimmest code and x select", 36'({inten, y_only, x_only}), 36'b10001);
    chk(irq_req == 0, "R8 no request while flags low", 36'(irq_req), 0);
    cyc(E_PEN);
    chk(irq_req == 7'h10, "R4 pen on channel 5", 36'(irq_req), 36'h10);
    cyc(E_LD);
    chk(disp_busy && if_ready && irq_req == 7'h14, "R3 R5 load sets busy and ready", 36'({disp_busy, if_ready, irq_req}), 36'h194);
    cyc(E_DN);
    chk(!disp_busy, "R3 done clears busy", 36'(disp_busy), 0);
    cyc(E_LD | E_DN);
    chk(disp_busy, "R3 load wins over done", 36'(disp_busy), 1);
    cyc(E_DCL);
    chk(!if_ready && irq_req == 7'h10, "R5 data clear drops ready", 36'({if_ready, irq_req}), 36'h10);
    cyc(E_LD | E_DCL);
    chk(if_ready, "R5 load wins over data clear", 36'(if_ready), 1);

    @(negedge clk); stat_rd = 1; #2;
    chk(rd_word == 36'h3B2B, "R6 full readback", rd_word, 36'h3B2B);
    @(negedge clk); #2;
    chk(irq_req[4], "R7 pen held during read", 36'(irq_req), 36'h14);
    @(negedge clk); stat_rd = 0; #2;
    chk(irq_req[4], "R7 pen held until edge sees low", 36'(irq_req), 36'h14);
    @(negedge clk); #2;
    chk(irq_req == 7'h04, "R7 read end clears pen", 36'(irq_req), 36'h04);

    cyc(E_PEN);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0; pen_hit = 1;
    @(negedge clk); pen_hit = 0; #2;
    chk(irq_req == 7'h14, "R4 hit wins over read end", 36'(irq_req), 36'h14);

    wr_word = 36'h0C0; cyc(E_CLR | E_SET); cyc(E_PEN); cyc(E_LD);
    chk(irq_req == 0, "R8 channel zero disables", 36'(irq_req), 0);
    chk(inten == 3'b011, "R9 brightest code", 36'(inten), 3);

    wr_word = 36'h012; cyc(E_CLR | E_SET); cyc(E_PEN); cyc(E_LD);
    chk(irq_req == 7'h02, "R8 shared channel 2", 36'(irq_req), 2);

    wr_word = 36'hF_FFFF_FFFF; cyc(E_CLR | E_SET | E_LD | E_PEN);
    @(negedge clk); stat_rd = 1; #2;
    chk(rd_word == 36'hFFF, "R1 R2 clear overrides events, high bits ignored", rd_word, 36'hFFF);
    @(negedge clk); stat_rd = 0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule